// File: doc/BRIEF.md
# Cassette pulse generator

This block rebuilds the one-bit signal that a tape-loading computer would read from its cassette input. It runs in processor T-states: each `tick_i` pulse is one T-state. It steps through a table of block descriptors, which it reads by index, and it pulls payload bytes through a request/acknowledge handshake. From these it produces pilot tones, sync pulses, data bits, raw pulse lists and silent gaps, each at its programmed width.

Loop blocks repeat a range of blocks. Pause blocks either delay or stop the tape. A block whose behaviour depends on the machine mode can halt playback on the smaller machine. Single-cycle play, stop and rewind pulses control the transport, and a status flag reports whether the tape is running.

Top module: `tape_pulse_gen`

## Requirements
- R1: After reset, `lvl_o`, `playing_o` and `byte_req_o` are 0 and `desc_idx_o` is 0. Whenever playback is stopped, `lvl_o` and `byte_req_o` are 0.
- R2: A standard block (kind code 0) takes its pilot width, its sync widths, its bit widths and a last-byte count of 8 from parameters. Its pilot count is the header-count parameter when the descriptor header flag is 1, and the data-count parameter otherwise.
- R3: Every half-period of the pilot lasts the pilot width in ticks, and the level toggles on each one, starting low. An odd pilot count is rounded up by one, so the pilot always ends high.
- R4: Bytes are read with `byte_req_o` held and `byte_addr_o` (base plus byte number) steady until `byte_ack_i`. Bits go out MSB first. Each bit is a low half-period followed by a high half-period, both of the zero width or both of the one width.
- R5: On the last byte of a non-standard block, only the leading N bits are sent, where N is the descriptor's last-bits field (1 to 8; 0 or more than 8 means 8). All other bytes send 8 bits.
- R6: After its data, a block holds the level low for its gap value times `TICKS_PER_MS` ticks.
- R7: A turbo block (kind 1) takes all of its widths and counts from the descriptor.
- R8: A pure-tone block (kind 2) emits only its pilot. It then moves straight on to the next block, with no sync, data or gap.
- R9: A pure-data block (kind 4) emits no pilot and no sync. It sends its data and then its gap.
- R10: A pulse-list block (kind 3) emits `pilot count[7:0]` half-periods. Half-period i has width `pul_w_i` while `pul_idx_o` = i. Even indices are low and odd indices are high.
- R11: A pause block (kind 5) with a non-zero gap holds the level low for the gap and then continues. With a zero gap it stops playback and advances the index by one.
- R12: Loop start (kind 6) loads the repeat count and records the index of the next block. Loop end (kind 7) decrements the count and returns to the recorded index while the result is non-zero.
- R13: The mode-stop block (kind 8) stops the tape without advancing when `mode48_i` is 1, and is skipped when it is 0. Running past the last block stops the tape and sets the index to 0. While stopped, the index holds.
- R14: `rewind_i` stops the tape and sets the index to 0. `stop_i` stops the tape and keeps the index. `play_i` restarts the current block from its beginning. Priority is rewind, then stop, then play.

The descriptor word `desc_i` is made of these fields, from the MSB down:

| Field | Bits |
|---|---|
| kind | 4 |
| header flag | 1 |
| pilot width | 16 |
| pilot count | 16 |
| sync-1 width | 16 |
| sync-2 width | 16 |
| zero width | 16 |
| one width | 16 |
| last-bits | 4 |
| gap (ms) | 16 |
| loop count | 16 |
| byte base | 24 |
| byte count | 24 |

Sync-1 is low and sync-2 is high. Control steps between timed phases take one clock each and are expected to fall between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One T-state elapsed |
| play_i | input | 1 | Start playback pulse |
| stop_i | input | 1 | Stop playback pulse |
| rewind_i | input | 1 | Stop and return to block 0 |
| mode48_i | input | 1 | Smaller-machine mode for the mode-stop block |
| num_blocks_i | input | IDX_W | Number of descriptors |
| desc_idx_o | output | IDX_W | Current block index |
| desc_i | input | DSC_W | Descriptor of the current block |
| pul_idx_o | output | 8 | Pulse-list entry index |
| pul_w_i | input | 16 | Width of the indexed pulse-list entry |
| byte_req_o | output | 1 | Payload byte request |
| byte_addr_o | output | 24 | Payload byte address |
| byte_ack_i | input | 1 | Byte delivered |
| byte_i | input | 8 | Payload byte |
| lvl_o | output | 1 | Cassette level |
| playing_o | output | 1 | Tape running |

## Verification
The hardest state to reach is a loop that returns to its recorded index more than once and then falls into a zero-gap pause. That pause halts the tape at an index that the next play must resume from. The stimulus builds a descriptor table in which a loop repeats a tone three times, followed by a delaying pause and a stopping pause. It plays the table twice and compares the level on every tick against a model built from the table. A mid-block stop and resume uses a deliberately long tone, which puts the stop inside the pilot.

// File: rtl/tape_pkg.sv
package tape_pkg;
  typedef enum logic [3:0] {
    KIND_STD    = 4'd0,
    KIND_TURBO  = 4'd1,
    KIND_TONE   = 4'd2,
    KIND_PULSES = 4'd3,
    KIND_PDATA  = 4'd4,
    KIND_PAUSE  = 4'd5,
    KIND_LOOP_S = 4'd6,
    KIND_LOOP_E = 4'd7,
    KIND_STOP48 = 4'd8
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic        hdr;
    logic [15:0] pilot_w;
    logic [15:0] pilot_n;
    logic [15:0] sync1_w;
    logic [15:0] sync2_w;
    logic [15:0] zero_w;
    logic [15:0] one_w;
    logic [3:0]  last_bits;
    logic [15:0] gap_ms;
    logic [15:0] loop_n;
    logic [23:0] base;
    logic [23:0] len;
  } dsc_t;

  localparam int DSC_W = $bits(dsc_t);

  typedef enum logic [3:0] {
    ST_IDLE, ST_NEXT, ST_PILOT, ST_SYNC1, ST_SYNC2,
    ST_FETCH, ST_BIT_LO, ST_BIT_HI, ST_GAP, ST_PSEQ
  } st_e;
endpackage

// File: rtl/tape_half_timer.sv
module tape_half_timer #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] width_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  // zero width finishes without consuming a tick
  assign done_o = (width_i == '0) || (tick_i && (cnt_q == width_i - W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || done_o)  cnt_q <= '0;
    else if (tick_i)           cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/tape_bit_shifter.sv
module tape_bit_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic [3:0] nbits_i,
  input  logic       shift_i,
  output logic       bit_o,
  output logic       last_o
);
  logic [7:0] sh_q;
  logic [3:0] nb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      nb_q <= '0;
    end else if (load_i) begin
      sh_q <= byte_i;
      nb_q <= nbits_i;
    end else if (shift_i) begin
      sh_q <= {sh_q[6:0], 1'b0};
      nb_q <= nb_q - 4'd1;
    end
  end

  assign bit_o  = sh_q[7];
  assign last_o = (nb_q <= 4'd1);
endmodule

// File: rtl/tape_pulse_gen.sv
module tape_pulse_gen
  import tape_pkg::*;
#(
  parameter int IDX_W        = 12,
  parameter int TIMER_W      = 32,
  parameter int STD_PILOT_W  = 2168,
  parameter int STD_HDR_N    = 8063,
  parameter int STD_DAT_N    = 3223,
  parameter int STD_SYNC1_W  = 667,
  parameter int STD_SYNC2_W  = 735,
  parameter int STD_ZERO_W   = 855,
  parameter int STD_ONE_W    = 1710,
  parameter int TICKS_PER_MS = 3500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             play_i,
  input  logic             stop_i,
  input  logic             rewind_i,
  input  logic             mode48_i,
  input  logic [IDX_W-1:0] num_blocks_i,
  output logic [IDX_W-1:0] desc_idx_o,
  input  logic [DSC_W-1:0] desc_i,
  output logic [7:0]       pul_idx_o,
  input  logic [15:0]      pul_w_i,
  output logic             byte_req_o,
  output logic [23:0]      byte_addr_o,
  input  logic             byte_ack_i,
  input  logic [7:0]       byte_i,
  output logic             lvl_o,
  output logic             playing_o
);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  st_e              st_q;
  logic [IDX_W-1:0] idx_q, loop_ret_q;
  logic [15:0]      loop_n_q;
  logic [16:0]      half_q;
  logic [7:0]       pidx_q;
  logic [23:0]      k_q;

  dsc_t             d;
  logic             is_std, is_turbo, is_tone, timed, done, last_byte;
  logic [15:0]      pil_w, pil_n, s1_w, s2_w, z_w, o_w;
  logic [16:0]      pil_tgt;
  logic [3:0]       lb, nbits;
  logic [TIMER_W-1:0] tw;
  logic             sh_bit, sh_last, sh_load, sh_shift;

  assign d        = dsc_t'(desc_i);
  assign is_std   = (d.kind == KIND_STD);
  assign is_turbo = (d.kind == KIND_TURBO);
  assign is_tone  = (d.kind == KIND_TONE);

  assign pil_w   = is_std ? 16'(STD_PILOT_W) : d.pilot_w;
  assign pil_n   = is_std ? (d.hdr ? 16'(STD_HDR_N) : 16'(STD_DAT_N)) : d.pilot_n;
  assign pil_tgt = {1'b0, pil_n} + 17'(pil_n[0]);  // round odd counts up
  assign s1_w    = is_std ? 16'(STD_SYNC1_W) : (is_turbo ? d.sync1_w : 16'd0);
  assign s2_w    = is_std ? 16'(STD_SYNC2_W) : (is_turbo ? d.sync2_w : 16'd0);
  assign z_w     = is_std ? 16'(STD_ZERO_W) : d.zero_w;
  assign o_w     = is_std ? 16'(STD_ONE_W) : d.one_w;
  assign lb      = (is_std || d.last_bits == 4'd0 || d.last_bits > 4'd8) ? 4'd8 : d.last_bits;
  assign last_byte = ((k_q + 24'd1) == d.len);
  assign nbits   = last_byte ? lb : 4'd8;

  always_comb begin
    unique case (st_q)
      ST_PILOT:            tw = TIMER_W'(pil_w);
      ST_SYNC1:            tw = TIMER_W'(s1_w);
      ST_SYNC2:            tw = TIMER_W'(s2_w);
      ST_BIT_LO, ST_BIT_HI: tw = TIMER_W'(sh_bit ? o_w : z_w);
      ST_GAP:              tw = TIMER_W'(d.gap_ms) * TIMER_W'(TICKS_PER_MS);
      ST_PSEQ:             tw = TIMER_W'(pul_w_i);
      default:             tw = '0;
    endcase
  end

  assign timed = st_q inside {ST_PILOT, ST_SYNC1, ST_SYNC2, ST_BIT_LO, ST_BIT_HI, ST_GAP, ST_PSEQ};

  tape_half_timer #(.W(TIMER_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!timed), .tick_i(tick_i),
    .width_i(tw), .done_o(done)
  );

  assign sh_load  = (st_q == ST_FETCH) && byte_ack_i;
  assign sh_shift = (st_q == ST_BIT_HI) && done && !sh_last;

  tape_bit_shifter u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(sh_load), .byte_i(byte_i),
    .nbits_i(nbits), .shift_i(sh_shift), .bit_o(sh_bit), .last_o(sh_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; idx_q <= '0; loop_ret_q <= '0; loop_n_q <= '0;
      half_q <= '0; pidx_q <= '0; k_q <= '0;
    end else if (rewind_i) begin
      st_q <= ST_IDLE; idx_q <= '0;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (play_i) st_q <= ST_NEXT;
        ST_NEXT: begin
          if (idx_q >= num_blocks_i) begin
            st_q <= ST_IDLE; idx_q <= '0;
          end else begin
            unique case (d.kind)
              KIND_STD, KIND_TURBO, KIND_TONE: begin
                half_q <= '0;
                if (pil_n != 16'd0)  st_q <= ST_PILOT;
                else if (is_tone)    idx_q <= idx_q + IDX_ONE;
                else                 st_q <= ST_SYNC1;
              end
              KIND_PDATA: st_q <= ST_SYNC1;
              KIND_PULSES: begin
                pidx_q <= '0;
                if (d.pilot_n[7:0] == 8'd0) idx_q <= idx_q + IDX_ONE;
                else                        st_q <= ST_PSEQ;
              end
              KIND_PAUSE: st_q <= ST_GAP;
              KIND_LOOP_S: begin
                loop_n_q   <= d.loop_n;
                loop_ret_q <= idx_q + IDX_ONE;
                idx_q      <= idx_q + IDX_ONE;
              end
              KIND_LOOP_E: begin
                loop_n_q <= loop_n_q - 16'd1;
                idx_q    <= (loop_n_q != 16'd1) ? loop_ret_q : idx_q + IDX_ONE;
              end
              KIND_STOP48: begin
                if (mode48_i) st_q <= ST_IDLE;
                else          idx_q <= idx_q + IDX_ONE;
              end
              default: st_q <= ST_IDLE;
            endcase
          end
        end
        ST_PILOT: if (done) begin
          if (half_q + 17'd1 >= pil_tgt) begin
            if (is_tone) begin idx_q <= idx_q + IDX_ONE; st_q <= ST_NEXT; end
            else st_q <= ST_SYNC1;
          end else half_q <= half_q + 17'd1;
        end
        ST_SYNC1: if (done) st_q <= ST_SYNC2;
        ST_SYNC2: if (done) begin
          k_q  <= '0;
          st_q <= (d.len == 24'd0) ? ST_GAP : ST_FETCH;
        end
        ST_FETCH:  if (byte_ack_i) st_q <= ST_BIT_LO;
        ST_BIT_LO: if (done) st_q <= ST_BIT_HI;
        ST_BIT_HI: if (done) begin
          if (!sh_last) st_q <= ST_BIT_LO;
          else begin
            k_q  <= k_q + 24'd1;
            st_q <= (k_q + 24'd1 < d.len) ? ST_FETCH : ST_GAP;
          end
        end
        ST_GAP: if (done) begin
          idx_q <= idx_q + IDX_ONE;
          st_q  <= (d.kind == KIND_PAUSE && d.gap_ms == 16'd0) ? ST_IDLE : ST_NEXT;
        end
        ST_PSEQ: if (done) begin
          if (pidx_q + 8'd1 >= d.pilot_n[7:0]) begin
            idx_q <= idx_q + IDX_ONE; st_q <= ST_NEXT;
          end else pidx_q <= pidx_q + 8'd1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign lvl_o = (st_q == ST_PILOT && half_q[0]) || (st_q == ST_SYNC2) ||
                 (st_q == ST_BIT_HI) || (st_q == ST_PSEQ && pidx_q[0]);
  assign playing_o   = (st_q != ST_IDLE);
  assign desc_idx_o  = idx_q;
  assign pul_idx_o   = pidx_q;
  assign byte_req_o  = (st_q == ST_FETCH);
  assign byte_addr_o = d.base + k_q;
endmodule

// File: rtl/tape_pulse_gen_chk.sv
module tape_pulse_gen_chk #(
  parameter int IDX_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             play_i,
  input logic             stop_i,
  input logic             rewind_i,
  input logic [IDX_W-1:0] desc_idx_o,
  input logic             byte_req_o,
  input logic [23:0]      byte_addr_o,
  input logic             byte_ack_i,
  input logic             lvl_o,
  input logic             playing_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !playing_o |-> (!lvl_o && !byte_req_o));

  p_req_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_req_o && !byte_ack_i && !stop_i && !rewind_i) |=> (byte_req_o && $stable(byte_addr_o)));

  p_idx_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!playing_o && !play_i && !rewind_i) |=> $stable(desc_idx_o));

  p_rewind_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_i |=> (!playing_o && desc_idx_o == '0));

  p_stop_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !playing_o);

  p_play_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_i && !playing_o && !stop_i && !rewind_i) |=> playing_o);
endmodule

bind tape_pulse_gen tape_pulse_gen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .play_i(play_i), .stop_i(stop_i),
  .rewind_i(rewind_i), .desc_idx_o(desc_idx_o), .byte_req_o(byte_req_o),
  .byte_addr_o(byte_addr_o), .byte_ack_i(byte_ack_i), .lvl_o(lvl_o),
  .playing_o(playing_o)
);

// File: tb/tape_pulse_gen_bench.sv
module tape_pulse_gen_bench;
  import tape_pkg::*;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int P_PW = 3, P_HN = 5, P_DN = 4, P_S1 = 2, P_S2 = 3;
  localparam int P_Z = 2, P_O = 4, P_TPM = 3;

  logic clk = 0, rst_n = 0;
  logic tick_i = 0, play_i = 0, stop_i = 0, rewind_i = 0, m48 = 0;
  logic [11:0] nblk = '0;
  logic [11:0] desc_idx;
  logic [DSC_W-1:0] desc;
  logic [7:0] pul_idx;
  logic [15:0] pul_w;
  logic byte_req, byte_ack = 0, lvl, playing;
  logic [23:0] byte_addr;
  logic [7:0] byte_d = '0;

  dsc_t tape[16];
  logic [7:0] mem[64];
  logic [15:0] pw[8];

  int n_chk = 0, n_fail = 0, exp_idx = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  assign desc  = tape[desc_idx[3:0]];
  assign pul_w = pw[pul_idx[2:0]];

  always @(negedge clk) begin
    byte_ack <= byte_req && !byte_ack;
    byte_d   <= mem[byte_addr[5:0]];
  end

  tape_pulse_gen #(
    .STD_PILOT_W(P_PW), .STD_HDR_N(P_HN), .STD_DAT_N(P_DN), .STD_SYNC1_W(P_S1),
    .STD_SYNC2_W(P_S2), .STD_ZERO_W(P_Z), .STD_ONE_W(P_O), .TICKS_PER_MS(P_TPM)
  ) u_tape_pulse_gen (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .play_i(play_i), .stop_i(stop_i),
    .rewind_i(rewind_i), .mode48_i(m48), .num_blocks_i(nblk), .desc_idx_o(desc_idx),
    .desc_i(desc), .pul_idx_o(pul_idx), .pul_w_i(pul_w), .byte_req_o(byte_req),
    .byte_addr_o(byte_addr), .byte_ack_i(byte_ack), .byte_i(byte_d), .lvl_o(lvl),
    .playing_o(playing)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic chk(input string r, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic dsc_t mk(kind_e k, bit hdr, int pilw, int piln, int s1, int s2,
                              int z, int o, int lbits, int gap, int ln, int base, int len);
    dsc_t t;
    t.kind = k; t.hdr = hdr; t.pilot_w = 16'(pilw); t.pilot_n = 16'(piln);
    t.sync1_w = 16'(s1); t.sync2_w = 16'(s2); t.zero_w = 16'(z); t.one_w = 16'(o);
    t.last_bits = 4'(lbits); t.gap_ms = 16'(gap); t.loop_n = 16'(ln);
    t.base = 24'(base); t.len = 24'(len);
    return t;
  endfunction

  task automatic push_n(input int n, input int v);
    for (int i = 0; i < n; i++) exp_q.push_back(v);
  endtask

  // R4 R5 R6: payload bits and trailing gap
  task automatic model_data(input dsc_t t);
    int lbits = (t.kind == KIND_STD || t.last_bits == 0 || t.last_bits > 8) ? 8 : int'(t.last_bits);
    int zw = (t.kind == KIND_STD) ? P_Z : int'(t.zero_w);
    int ow = (t.kind == KIND_STD) ? P_O : int'(t.one_w);
    for (int k = 0; k < int'(t.len); k++) begin
      int nb = (k == int'(t.len) - 1) ? lbits : 8;
      for (int b = 0; b < nb; b++) begin
        int w = mem[int'(t.base) + k][7-b] ? ow : zw;
        push_n(w, 0);
        push_n(w, 1);
      end
    end
    push_n(int'(t.gap_ms) * P_TPM, 0);
  endtask

  task automatic model(input int start);
    int idx = start;
    int lc = 0, ret = 0;
    exp_q.delete();
    forever begin
      dsc_t t;
      if (idx >= int'(nblk)) begin idx = 0; break; end
      t = tape[idx];
      if (t.kind == KIND_STD || t.kind == KIND_TURBO || t.kind == KIND_TONE) begin
        bit std = (t.kind == KIND_STD);
        int w = std ? P_PW : int'(t.pilot_w);
        int n = std ? (t.hdr ? P_HN : P_DN) : int'(t.pilot_n);
        n = n + (n % 2);
        for (int h = 0; h < n; h++) push_n(w, h % 2);
        if (t.kind != KIND_TONE) begin
          push_n(std ? P_S1 : int'(t.sync1_w), 0);
          push_n(std ? P_S2 : int'(t.sync2_w), 1);
          model_data(t);
        end
        idx++;
      end else if (t.kind == KIND_PDATA) begin
        model_data(t); idx++;
      end else if (t.kind == KIND_PULSES) begin
        for (int i = 0; i < int'(t.pilot_n[7:0]); i++) push_n(int'(pw[i]), i % 2);
        idx++;
      end else if (t.kind == KIND_PAUSE) begin
        push_n(int'(t.gap_ms) * P_TPM, 0);
        idx++;
        if (t.gap_ms == 0) break;
      end else if (t.kind == KIND_LOOP_S) begin
        lc = int'(t.loop_n); ret = idx + 1; idx++;
      end else if (t.kind == KIND_LOOP_E) begin
        lc = (lc - 1) & 16'hFFFF;
        idx = (lc != 0) ? ret : idx + 1;
      end else if (t.kind == KIND_STOP48) begin
        if (m48) break;
        idx++;
      end else break;
    end
    exp_idx = idx;
  endtask

  // plays from the current index, compares the level on every tick
  task automatic run(input string tag, input int start, input int limit);
    int n = 0, cyc = 0, e;
    model(start);
    @(negedge clk) play_i = 1;
    @(negedge clk) play_i = 0;
    while (exp_q.size() > 0 && n < limit) begin
      @(negedge clk);
      cyc++;
      tick_i = (cyc % 16 == 0);
      if (tick_i) begin
        e = exp_q.pop_front();
        chk(tag, lvl, e);
        n++;
      end
    end
    @(negedge clk) tick_i = 0;
    if (n < limit) begin
      repeat (20) @(negedge clk);
      chk("R13 stopped at end", playing, 0);
      chk("R13 final index", desc_idx, exp_idx);
      chk("R1 level low when stopped", lvl, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) tape[i] = '0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int i = 0; i < 8; i++) pw[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 level", lvl, 0);
    chk("R1 playing", playing, 0);
    chk("R1 request", byte_req, 0);
    chk("R1 index", desc_idx, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R6: standard header and data blocks
    mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'h81;
    tape[0] = mk(KIND_STD, 1, 0, 0, 0, 0, 0, 0, 3, 1, 0, 0, 2);
    tape[1] = mk(KIND_STD, 0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 2, 1);
    nblk = 2;
    run("R2 R3 R4 R6 standard blocks", 0, 100000);

    // R7 R5 R8 R9 R10: turbo, tone, pure data, pulse list
    mem[3] = 8'hF0; mem[4] = 8'hA0; mem[5] = 8'h58;
    pw[0] = 1; pw[1] = 2; pw[2] = 3; pw[3] = 1; pw[4] = 2;
    tape[0] = mk(KIND_TURBO, 0, 2, 3, 1, 2, 1, 3, 3, 1, 0, 3, 2);
    tape[1] = mk(KIND_TONE, 0, 2, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    tape[2] = mk(KIND_PDATA, 0, 0, 0, 9, 9, 2, 1, 5, 0, 0, 5, 1);
    tape[3] = mk(KIND_PULSES, 0, 0, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    nblk = 4;
    run("R5 R7 R8 R9 R10 mixed kinds", 0, 100000);

    // R12 R11: loop of three tones, delaying pause, stopping pause
    tape[0] = mk(KIND_LOOP_S, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0, 0);
    tape[1] = mk(KIND_TONE, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    tape[2] = mk(KIND_LOOP_E, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    tape[3] = mk(KIND_PAUSE, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    tape[4] = mk(KIND_PAUSE, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    tape[5] = mk(KIND_TONE, 0, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    nblk = 6;
    run("R11 R12 loop and pause", 0, 100000);
    chk("R11 zero pause index", desc_idx, 5);
    run("R11 resume after pause", 5, 100000);

    // R13: mode-stop block
    tape[0] = mk(KIND_TONE, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    tape[1] = mk(KIND_STOP48, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    tape[2] = mk(KIND_PULSES, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    pw[0] = 1; pw[1] = 2; pw[2] = 1;
    nblk = 3;
    m48 = 1;
    run("R13 mode stop taken", 0, 100000);
    chk("R13 mode stop holds index", desc_idx, 1);
    m48 = 0;
    run("R13 mode stop skipped", 1, 100000);

    // R14: stop mid-pilot, resume, rewind
    tape[0] = mk(KIND_PULSES, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    tape[1] = mk(KIND_TONE, 0, 3, 40, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    pw[0] = 1;
    nblk = 2;
    run("R14 before stop", 0, 12);
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
    chk("R14 stop halts", playing, 0);
    chk("R14 stop level low", lvl, 0);
    chk("R14 stop keeps index", desc_idx, 1);
    run("R14 resume restarts block", 1, 8);
    @(negedge clk) rewind_i = 1;
    @(negedge clk) rewind_i = 0;
    chk("R14 rewind halts", playing, 0);
    chk("R14 rewind index", desc_idx, 0);
    repeat (5) @(negedge clk);
    chk("R13 idle index steady", desc_idx, 0);

    summary();
    $finish;
  end
endmodule